// File: doc/BRIEF.md
# Frame-Aligning Four-Lane Bit Deinterleaver

This block takes a recovered serial bitstream, one bit per accepted transfer, and deals the bits round-robin onto four parallel lanes. Each lane then runs at one quarter of the serial rate. Upstream bit interleaving carries four independent channels, but the receiver cannot know at which bit the interleave cycle starts. A lane-rotation index is therefore applied to every assembled word. The designated lane (lane 0) is watched for the synchronous-transport framing pattern. While no frame is held, the rotation is stepped one position per frame time until the pattern appears on that lane, and from then on every channel leaves on its own fixed lane.

The serial side and the lane side are both valid/ready streams. A serial bit is taken on a cycle where `s_valid` and `s_ready` are both high. A lane word is handed over on a cycle where `m_valid` and `m_ready` are both high. `s_ready` is high whenever the output register is empty or is being emptied in the same cycle. While a word waits with `m_ready` low, the block accepts no serial bits, and the waiting word stays unchanged. Neither side loses or repeats a bit under any pattern of stalls.

A loss-of-frame flag and a parallel clock enable are plain outputs. The enable pulses once per lane word, or once per four lane words, depending on a parameter.

Top module: `lane_roll_deint`

## Requirements
- R1: Within one word, the first accepted serial bit is bit 0 of the assembled word. Output lane k carries assembled bit (k + rotation) mod 4. The rotation is 0 after reset, so a channel-aligned stream places channel k on `m_data[k]`.
- R2: While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` hold their values and `s_ready` is low.
- R3: Gaps in `s_valid` and stalls on `m_ready` neither drop nor duplicate serial bits, and channel-to-lane mapping is kept.
- R4: The framing pattern is three 0xF6 bytes followed by three 0x28 bytes, taken most significant bit first, on the lane-0 bit sequence. That sequence carries 24 ones per frame of `FRAME_LEN` lane bits.
- R5: While out of frame, if `FRAME_LEN` lane words pass without a pattern match, the rotation advances by exactly one and the pattern search starts again from an empty history.
- R6: `lof` falls only after two pattern matches spaced exactly `FRAME_LEN` lane words apart.
- R7: While in frame, the pattern is expected every `FRAME_LEN` lane words. `lof` rises when four consecutive expected positions miss, and not sooner.
- R8: While `lof` is low the rotation never changes. When `lof` rises, the rotation is kept, so a returning pattern relocks on the same mapping within two frame times.
- R9: `pclk_en` is a one-cycle pulse, issued once every `PCLK_DIV` lane words, in the cycle a new word appears on `m_data`.
- R10: During and right after reset, `lof` is 1, `m_valid` is 0, `pclk_en` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Serial bit present |
| s_bit | input | 1 | Serial data bit |
| s_ready | output | 1 | Block can take a serial bit |
| m_valid | output | 1 | Lane word present |
| m_ready | input | 1 | Consumer takes the lane word |
| m_data | output | LANES | Lane word, bit k is lane k |
| lof | output | 1 | Loss of frame, high while hunting |
| pclk_en | output | 1 | Divided parallel clock enable pulse |

## Verification
On every cycle, the assertions check the following:
- A stalled word stays held.
- The rotation only ever steps by one, and only while out of frame.
- A step always clears the pattern history.
- The loss flag changes state only on a word boundary: it falls on a match and rises on a frame check.
- The clock enable never lasts two cycles.

Only the bench scenarios can show the end-to-end properties:
- Each of the four starting bit phases converges to the correct channel order.
- No bit is lost under input gaps and output stalls.
- Exactly four missed frames are needed to declare loss.
- Relock happens without a roll.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

  // framing bytes, sent most significant bit first
  localparam logic [7:0] SYNC_HI = 8'hF6;
  localparam logic [7:0] SYNC_LO = 8'h28;

  typedef enum logic {
    MODE_HUNT = 1'b0,
    MODE_SYNC = 1'b1
  } frm_mode_e;

endpackage

// File: rtl/lrd_gather.sv
module lrd_gather #(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_bit,
  output logic             s_ready,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [LANES-1:0] m_data,
  input  logic             roll,
  output logic [CW-1:0]    rot,
  output logic             load_o
);

  logic [CW-1:0]    cnt;
  logic [LANES-2:0] acc;
  logic             take;
  logic             last;
  logic [LANES-1:0] word;
  logic [LANES-1:0] rotd;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;
  assign last    = (cnt == CW'(LANES - 1));
  assign word    = {s_bit, acc};

  // lane k takes assembled bit (k + rot) mod LANES
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rotd[k] = word[CW'(k) + rot];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      acc     <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      rot     <= '0;
      load_o  <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (roll) rot <= rot + CW'(1);
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (take) begin
        if (last) begin
          m_data  <= rotd;
          m_valid <= 1'b1;
          load_o  <= 1'b1;
          cnt     <= '0;
        end else begin
          acc <= {s_bit, acc[LANES-2:1]};
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R2: a stalled word is held unchanged
  assert_hold_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R5: the rotation moves only by a single step
  assert_rot_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rot) |-> (rot == $past(rot) + CW'(1)));

endmodule

// File: rtl/lrd_sync_match.sv
module lrd_sync_match
  import lrd_pkg::*;
#(
  parameter int PAT_REP = 3,
  localparam int PW = 16 * PAT_REP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic clr,
  output logic hit
);

  logic [PW-1:0] sr;
  logic [PW-1:0] nxt;
  logic [PW-1:0] pat;

  for (genvar r = 0; r < PAT_REP; r++) begin : g_pat
    assign pat[PW-1-8*r -: 8]          = SYNC_HI;
    assign pat[8*PAT_REP-1-8*r -: 8]   = SYNC_LO;
  end

  assign nxt = {sr[PW-2:0], bit_in};
  assign hit = bit_valid && (nxt == pat);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sr <= '0;
    end else if (bit_valid) begin
      sr <= nxt;
    end
  end

  // R5: clearing the history rules out an immediate match
  assert_clear_history_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hit);

endmodule

// File: rtl/lrd_frame_ctrl.sv
module lrd_frame_ctrl
  import lrd_pkg::*;
#(
  parameter int FRAME_LEN = 9720,
  parameter int LOSS_N    = 4,
  parameter int GAIN_N    = 2,
  localparam int PCW = $clog2(FRAME_LEN),
  localparam int MW  = $clog2(LOSS_N + 1),
  localparam int GW  = $clog2(GAIN_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  output logic roll,
  output logic lof
);

  frm_mode_e      mode;
  logic [PCW-1:0] pos;
  logic           anchor;
  logic [GW-1:0]  good;
  logic [MW-1:0]  miss;
  logic           at_end;

  assign at_end = (pos == PCW'(FRAME_LEN - 1));
  assign lof    = (mode == MODE_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= MODE_HUNT;
      pos    <= '0;
      anchor <= 1'b0;
      good   <= '0;
      miss   <= '0;
      roll   <= 1'b0;
    end else begin
      roll <= 1'b0;
      if (tick) begin
        if (mode == MODE_HUNT) begin
          if (hit) begin
            pos <= '0;
            if (anchor && at_end) begin
              if ((good + GW'(1)) >= GW'(GAIN_N)) begin
                mode   <= MODE_SYNC;
                miss   <= '0;
                good   <= '0;
                anchor <= 1'b0;
              end else begin
                good <= good + GW'(1);
              end
            end else begin
              anchor <= 1'b1;
              good   <= GW'(1);
            end
          end else if (at_end) begin
            roll   <= 1'b1;
            anchor <= 1'b0;
            good   <= '0;
            pos    <= '0;
          end else begin
            pos <= pos + PCW'(1);
          end
        end else begin
          if (at_end) begin
            pos <= '0;
            if (hit) begin
              miss <= '0;
            end else if ((miss + MW'(1)) == MW'(LOSS_N)) begin
              mode   <= MODE_HUNT;
              miss   <= '0;
              anchor <= 1'b0;
              good   <= '0;
            end else begin
              miss <= miss + MW'(1);
            end
          end else begin
            pos <= pos + PCW'(1);
          end
        end
      end
    end
  end

  // R8: rolls happen only while out of frame
  assert_no_roll_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    roll |-> lof);

  // R7: loss is declared only at a word boundary
  assert_lof_rise_on_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> $past(tick));

  // R6: frame is gained only on a match
  assert_lof_fall_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> $past(hit));

  // R7: miss counter stays below the loss threshold
  assert_miss_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss < MW'(LOSS_N));

endmodule

// File: rtl/lrd_pclk_div.sv
module lrd_pclk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic pclk_en
);

  if (DIV <= 1) begin : g_direct
    assign pclk_en = tick;
  end else begin : g_count
    localparam int DW = $clog2(DIV);
    logic [DW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= (cnt == DW'(DIV - 1)) ? '0 : cnt + DW'(1);
      end
    end
    assign pclk_en = tick && (cnt == DW'(DIV - 1));
  end

  // R9: the enable is a single-cycle pulse
  assert_pclk_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |=> !pclk_en);

endmodule

// File: rtl/lane_roll_deint.sv
module lane_roll_deint #(
  parameter int LANES      = 4,
  parameter int FRAME_LEN  = 9720,
  parameter int PAT_REP    = 3,
  parameter int LOSS_N     = 4,
  parameter int GAIN_N     = 2,
  parameter int FRAME_LANE = 0,
  parameter int PCLK_DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_bit,
  output logic             s_ready,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [LANES-1:0] m_data,
  output logic             lof,
  output logic             pclk_en
);

  localparam int CW = $clog2(LANES);

  logic [CW-1:0] rot;
  logic          roll;
  logic          load;
  logic          hit;

  lrd_gather #(.LANES(LANES)) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_bit   (s_bit),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .roll    (roll),
    .rot     (rot),
    .load_o  (load)
  );

  lrd_sync_match #(.PAT_REP(PAT_REP)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (load),
    .bit_in    (m_data[FRAME_LANE]),
    .clr       (roll),
    .hit       (hit)
  );

  lrd_frame_ctrl #(
    .FRAME_LEN (FRAME_LEN),
    .LOSS_N    (LOSS_N),
    .GAIN_N    (GAIN_N)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (load),
    .hit   (hit),
    .roll  (roll),
    .lof   (lof)
  );

  lrd_pclk_div #(.DIV(PCLK_DIV)) u_pclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (load),
    .pclk_en (pclk_en)
  );

  // R8: lane mapping frozen while in frame
  assert_rot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lof |=> $stable(rot));

endmodule

// File: tb/lane_roll_deint_bench.sv
module lane_roll_deint_bench;

  localparam int FL  = 64;
  localparam int DIV = 4;
  localparam logic [47:0] PAT = 48'hF6F6F6282828;
  localparam int ONES = 24;
  // {bit offset, s_valid gap mode, m_ready stall mode}
  localparam int SCN [4][3] = '{'{0, 0, 0}, '{1, 1, 0}, '{2, 0, 1}, '{3, 1, 1}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_bit = 1'b0;
  logic       s_ready;
  logic       m_valid;
  logic       m_ready = 1'b0;
  logic [3:0] m_data;
  logic       lof;
  logic       pclk_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  longint idx = 0;
  bit     hs_pend = 1'b0;
  int     off = 0, vmode = 0, rmode = 0;
  bit     stall = 1'b0;
  int     pat_off_from = 1 << 30;
  int     pat_on_again = 0;
  int     cur_frame = 0, cur_fb = 0;
  int     cyc = 0;
  bit     mon_on = 1'b0;
  int     mon_words = 0, mon_ones = 0, mon_bad = 0;

  always #10 clk = ~clk;

  lane_roll_deint #(.FRAME_LEN(FL), .PCLK_DIV(DIV)) u_lane_roll_deint (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_bit   (s_bit),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .lof     (lof),
    .pclk_en (pclk_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver and monitor: inputs change at the falling edge only
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (hs_pend) idx++;
      begin
        longint j;
        int ch, cb, fb, fr;
        bit b;
        b = 1'b0;
        if (idx >= off) begin
          j  = idx - off;
          ch = int'(j % 4);
          cb = int'(j / 4);
          fb = cb % FL;
          fr = cb / FL;
          cur_frame = fr;
          cur_fb    = fb;
          case (ch)
            0: b = (!(fr >= pat_off_from && fr < pat_on_again) && fb < 48) ? PAT[47-fb] : 1'b0;
            1: b = 1'b1;
            2: b = 1'b0;
            default: b = 1'b1;
          endcase
        end
        s_bit = b;
      end
      s_valid = rst_n && !(vmode == 1 && (cyc % 3) == 0);
      m_ready = !stall && !(rmode == 1 && (cyc % 2) == 0);
      #1;
      hs_pend = s_valid && s_ready;
      if (mon_on && mon_words < FL && m_valid && m_ready) begin
        mon_words++;
        if (m_data[3:1] != 3'b101) mon_bad++;
        mon_ones += int'(m_data[0]);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    stall = 1'b0;
    pat_off_from = 1 << 30;
    pat_on_again = 0;
    @(negedge clk); #3;
    idx = 0;
    hs_pend = 1'b0;
    repeat (2) @(negedge clk);
    #3 rst_n = 1'b1;
  endtask

  task automatic wait_lock(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #2;
      if (!lof) break;
    end
  endtask

  task automatic mon_frame();
    mon_words = 0; mon_ones = 0; mon_bad = 0;
    mon_on = 1'b1;
    while (mon_words < FL) begin
      @(negedge clk); #2;
    end
    mon_on = 1'b0;
  endtask

  task automatic wait_frame(input int fr, input int fb);
    while (!(cur_frame > fr || (cur_frame == fr && cur_fb >= fb))) begin
      @(negedge clk); #2;
    end
  endtask

  initial begin
    // watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    do_reset();
    #1;
    chk(lof == 1'b1, "R10", "lof after reset", int'(lof), 1);
    chk(m_valid == 1'b0, "R10", "m_valid after reset", int'(m_valid), 0);
    chk(pclk_en == 1'b0, "R10", "pclk_en after reset", int'(pclk_en), 0);
    chk(s_ready == 1'b1, "R10", "s_ready after reset", int'(s_ready), 1);

    // table walk: every starting phase, with gaps and stalls
    for (int s = 0; s < 4; s++) begin
      off = SCN[s][0]; vmode = SCN[s][1]; rmode = SCN[s][2];
      do_reset();
      wait_lock(20000);
      chk(lof == 1'b0, "R5/R6", $sformatf("lock offset %0d", off), int'(lof), 0);
      mon_frame();
      chk(mon_bad == 0, "R1/R3", $sformatf("lane order offset %0d", off), mon_bad, 0);
      chk(mon_ones == ONES, "R4", $sformatf("lane0 ones offset %0d", off), mon_ones, ONES);
    end

    // R2 stall hold
    off = 1; vmode = 0; rmode = 0;
    do_reset();
    wait_lock(20000);
    stall = 1'b1;
    repeat (8) @(negedge clk);
    #2;
    begin
      logic [3:0] held;
      held = m_data;
      repeat (6) @(negedge clk);
      #2;
      chk(m_valid == 1'b1, "R2", "m_valid held", int'(m_valid), 1);
      chk(m_data == held, "R2", "m_data held", int'(m_data), int'(held));
      chk(s_ready == 1'b0, "R2", "s_ready during stall", int'(s_ready), 0);
    end
    stall = 1'b0;
    mon_frame();
    chk(mon_bad == 0, "R3", "lanes after stall", mon_bad, 0);
    chk(mon_ones == ONES, "R3", "lane0 after stall", mon_ones, ONES);
    chk(lof == 1'b0, "R3", "frame kept over stall", int'(lof), 0);

    // R7 / R8 loss and relock
    begin
      int f;
      f = cur_frame + 2;
      pat_on_again = f + 4;
      pat_off_from = f;
      wait_frame(f, 50);
      mon_frame();
      chk(mon_bad == 0, "R8", "no roll while missing", mon_bad, 0);
      wait_frame(f + 3, 20);
      chk(lof == 1'b0, "R7", "three misses keep frame", int'(lof), 0);
      wait_frame(f + 4, 20);
      chk(lof == 1'b1, "R7", "four misses lose frame", int'(lof), 1);
      wait_frame(f + 5, 60);
      chk(lof == 1'b0, "R8", "relock without roll", int'(lof), 0);
      mon_frame();
      chk(mon_bad == 0, "R8", "mapping after relock", mon_bad, 0);
    end

    // R9 enable spacing with free-flowing stream
    begin
      int first, second, n;
      first = -1; second = -1; n = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk); #2;
        if (pclk_en) begin
          n++;
          if (first < 0) first = i;
          else if (second < 0) second = i;
        end
      end
      chk(second - first == 4 * DIV, "R9", "enable spacing", second - first, 4 * DIV);
      chk(n >= 24 && n <= 26, "R9", "enable count", n, 25);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule